// File: doc/BRIEF.md
# Logarithmic 8-bit Integer Codec

This block converts unsigned 20-bit integers into compact 8-bit logarithmic symbols and turns symbols back into integers. A symbol carries an exponent in its upper nibble and a mantissa in its lower nibble. The value range is split into sixteen linear segments. Segment `e` starts at `(2^e - 1) * 16` and has a step size of `2^e`. The result is a quantiser whose relative error stays at or below 6.25 percent over 0 to 1,015,792.

The two directions are separate datapaths. Each has its own valid/ready handshake, and each can run while the other is busy. The encoder makes a first guess at the exponent from the position of the leading one. It then corrects that guess one step per cycle, moving down while the value lies below the segment base and up while the value reaches the next base. After that it extracts the mantissa. The decoder needs one register stage.

Top module: `logq_codec`

## Requirements
- R1: A symbol's exponent is bits [7:4] and its mantissa is bits [3:0]. The decoder returns `(mantissa << exponent) + (2^exponent - 1) * 16`.
- R2: An encoder input below 16 comes back as a symbol equal to the input (exponent 0).
- R3: For an input v up to 1,015,792, the encoder picks the largest exponent e in 0..15 whose segment base `(2^e - 1) * 16` does not exceed v. The mantissa is `((v - base) >> e) & 0xF`.
- R4: For each of the 256 symbols, decoding and then re-encoding returns the same symbol. Decoded values rise strictly as the symbol increases.
- R5: Encoder inputs above 1,015,792 saturate to symbol 0xFF. No decoded value exceeds 1,015,792.
- R6: The encoder symbol becomes valid on the 4th rising edge after the input is accepted. It becomes valid on the 5th edge when the leading-one guess needs one upward correction. Each further correction step adds one more edge.
- R7: While the encoder result is valid and not taken, the symbol is held stable and the encoder input ready stays low. The encoder accepts input again on the cycle after the result is taken.
- R8: The decoder result is valid on the edge after acceptance and is held stable while not taken. The decoder input ready is high whenever its output is empty or is being taken.
- R9: The encoder and the decoder operate concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encInValid | input | 1 | Encoder input value present |
| encInReady | output | 1 | Encoder can accept a value |
| encInValue | input | 20 | Integer to compress |
| encOutValid | output | 1 | Encoder symbol present |
| encOutReady | input | 1 | Consumer takes the encoder symbol |
| encOutCode | output | 8 | Compressed symbol |
| decInValid | input | 1 | Decoder symbol present |
| decInReady | output | 1 | Decoder can accept a symbol |
| decInCode | input | 8 | Symbol to expand |
| decOutValid | output | 1 | Decoder value present |
| decOutReady | input | 1 | Consumer takes the decoder value |
| decOutValue | output | 20 | Reconstructed integer |

## Verification
The decoder value is due on the first rising edge after acceptance. The encoder symbol is due four edges after acceptance, plus one edge for every exponent correction step. The bench model derives that correction count from the value itself. The bench drives and samples on falling edges. For each encoder transaction it counts the edges from acceptance until the valid output appears and compares the count with the model's due cycle. It then holds the consumer ready low for several cycles and checks at every falling edge that the result is stable.

// File: rtl/logq_pkg.sv
package logq_pkg;
  localparam int VAL_W   = 20;
  localparam int EXP_W   = 4;
  localparam int MAN_W   = 4;
  localparam int CODE_W  = EXP_W + MAN_W;
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CLZ_W   = 32;
  localparam int LZ_W    = $clog2(CLZ_W) + 1;
  localparam int STEP    = 1 << MAN_W;

  typedef struct packed {
    logic load;
    logic seed;
    logic stepDown;
    logic stepUp;
    logic finish;
  } encStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEED, ST_DOWN, ST_UP, ST_FIN, ST_HOLD
  } encState_t;

  // base of segment e: a run of e ones, scaled by the segment step count
  function automatic logic [VAL_W-1:0] segBase(input logic [EXP_W-1:0] e);
    logic [VAL_W-1:0] ramp;
    ramp = VAL_W'(15'h7FFF) >> (EXP_W'(MAX_EXP) - e);
    return ramp << MAN_W;
  endfunction
endpackage

// File: rtl/logq_clz.sv
module logq_clz
  import logq_pkg::*;
#(
  parameter int W   = CLZ_W,
  localparam int LVL = $clog2(W),
  localparam int CW  = LVL + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  logic [W-1:0]  part  [0:LVL];
  logic [CW-1:0] count [0:LVL];

  assign part[0]  = vec;
  assign count[0] = CW'(W);

  for (genvar i = 0; i < LVL; i++) begin : g_halve
    localparam int SH = W >> (i + 1);
    logic [W-1:0] upper;
    assign upper        = part[i] >> SH;
    assign part[i+1]    = (upper != '0) ? upper : part[i];
    assign count[i+1]   = (upper != '0) ? count[i] - CW'(SH) : count[i];
  end

  assign zeros = count[LVL] - CW'(part[LVL][0]);
endmodule

// File: rtl/logq_enc_ctrl.sv
module logq_enc_ctrl
  import logq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       canDown,
  input  logic       canUp,
  output logic       inReady,
  output logic       outValid,
  output encStrobe_t strb
);
  encState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        strb.load = 1'b1;
        nextState = ST_SEED;
      end
      ST_SEED: begin
        strb.seed = 1'b1;
        nextState = ST_DOWN;
      end
      ST_DOWN: begin
        if (canDown) strb.stepDown = 1'b1;
        else         nextState = ST_UP;
      end
      ST_UP: begin
        if (canUp) strb.stepUp = 1'b1;
        else       nextState = ST_FIN;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        nextState = ST_HOLD;
      end
      ST_HOLD: if (outReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_HOLD);
endmodule

// File: rtl/logq_enc_dp.sv
module logq_enc_dp
  import logq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strb,
  input  logic [VAL_W-1:0]  inValue,
  output logic              canDown,
  output logic              canUp,
  output logic [CODE_W-1:0] code
);
  logic [VAL_W-1:0]  valReg, offReg;
  logic [EXP_W-1:0]  expReg;
  logic [CODE_W-1:0] codeReg;
  logic [LZ_W-1:0]   lz;
  logic signed [7:0] estRaw;
  logic [EXP_W-1:0]  seedExp;
  logic [VAL_W:0]    nextOff;
  logic [VAL_W-1:0]  diff, raw;
  logic [MAN_W-1:0]  mant;

  logq_clz #(.W(CLZ_W)) u_clz (
    .vec  (CLZ_W'(valReg)),
    .zeros(lz)
  );

  always_comb begin
    estRaw = $signed(8'(CLZ_W - 1 - MAN_W)) - $signed(8'(lz));
    if (estRaw < 0)                      seedExp = '0;
    else if (estRaw > 8'(MAX_EXP))       seedExp = EXP_W'(MAX_EXP);
    else                                 seedExp = estRaw[EXP_W-1:0];
  end

  assign nextOff = {offReg, 1'b0} + (VAL_W+1)'(STEP);
  assign canDown = (expReg != '0) && (valReg < offReg);
  assign canUp   = (expReg != EXP_W'(MAX_EXP)) && ({1'b0, valReg} >= nextOff);

  assign diff = valReg - offReg;
  assign raw  = diff >> expReg;
  assign mant = (raw[VAL_W-1:MAN_W] != '0) ? '1 : raw[MAN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valReg  <= '0;
      offReg  <= '0;
      expReg  <= '0;
      codeReg <= '0;
    end else begin
      if (strb.load) valReg <= inValue;
      if (strb.seed) begin
        expReg <= seedExp;
        offReg <= segBase(seedExp);
      end
      if (strb.stepDown) begin
        expReg <= expReg - 1'b1;
        offReg <= (offReg - VAL_W'(STEP)) >> 1;
      end
      if (strb.stepUp) begin
        expReg <= expReg + 1'b1;
        offReg <= nextOff[VAL_W-1:0];
      end
      if (strb.finish) codeReg <= {expReg, mant};
    end
  end

  assign code = codeReg;
endmodule

// File: rtl/logq_dec.sv
module logq_dec
  import logq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [VAL_W-1:0]  outValue
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic [VAL_W-1:0] expanded;
  logic             take;

  assign e        = inCode[CODE_W-1:MAN_W];
  assign m        = inCode[MAN_W-1:0];
  assign expanded = (VAL_W'(m) << e) + segBase(e);
  assign inReady  = !outValid || outReady;
  assign take     = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outValue <= '0;
    end else if (take) begin
      outValid <= 1'b1;
      outValue <= expanded;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/logq_codec.sv
module logq_codec
  import logq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        encInValid,
  output logic        encInReady,
  input  logic [19:0] encInValue,
  output logic        encOutValid,
  input  logic        encOutReady,
  output logic [7:0]  encOutCode,
  input  logic        decInValid,
  output logic        decInReady,
  input  logic [7:0]  decInCode,
  output logic        decOutValid,
  input  logic        decOutReady,
  output logic [19:0] decOutValue
);
  encStrobe_t strb;
  logic       canDown, canUp;

  logq_enc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (encInValid),
    .outReady(encOutReady),
    .canDown (canDown),
    .canUp   (canUp),
    .inReady (encInReady),
    .outValid(encOutValid),
    .strb    (strb)
  );

  logq_enc_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inValue(encInValue),
    .canDown(canDown),
    .canUp  (canUp),
    .code   (encOutCode)
  );

  logq_dec u_dec (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (decInValid),
    .inReady (decInReady),
    .inCode  (decInCode),
    .outValid(decOutValid),
    .outReady(decOutReady),
    .outValue(decOutValue)
  );
endmodule

// File: rtl/logq_codec_chk.sv
module logq_codec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        encInValid,
  input logic        encInReady,
  input logic [19:0] encInValue,
  input logic        encOutValid,
  input logic        encOutReady,
  input logic [7:0]  encOutCode,
  input logic        decInValid,
  input logic        decInReady,
  input logic [7:0]  decInCode,
  input logic        decOutValid,
  input logic        decOutReady,
  input logic [19:0] decOutValue
);
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid && !encOutReady |=> encOutValid && $stable(encOutCode)); // R7
  AST_ENC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid |-> !encInReady); // R7
  AST_ENC_REOPEN: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid && encOutReady |=> encInReady && !encOutValid); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> decOutValid && $stable(decOutValue)); // R8
  AST_DEC_RESP: assert property (@(posedge clk) disable iff (!rstN)
    decInValid && decInReady |=> decOutValid); // R8
  AST_DEC_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid |-> decOutValue <= 20'd1015792); // R5
endmodule

bind logq_codec logq_codec_chk u_chk (.*);

// File: tb/sim_logq_codec.sv
module sim_logq_codec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encInValid = 1'b0, encOutReady = 1'b0;
  logic [19:0] encInValue = '0;
  logic        decInValid = 1'b0, decOutReady = 1'b0;
  logic [7:0]  decInCode = '0;
  logic        encInReady, encOutValid, decInReady, decOutValid;
  logic [7:0]  encOutCode;
  logic [19:0] decOutValue;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  logq_codec u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint base(input int e);
    return ((longint'(1) << e) - 1) * 16;
  endfunction

  function automatic int refDec(input int c);
    return int'((longint'(c % 16) << (c / 16)) + base(c / 16));
  endfunction

  function automatic int refEnc(input longint v);
    int e = 0;
    longint m;
    if (v > 1015792) return 255;
    for (int k = 0; k <= 15; k++) if (base(k) <= v) e = k;
    m = (v - base(e)) >> e;
    return e * 16 + int'(m & 15);
  endfunction

  function automatic int refLat(input longint v);
    int p = -1, e, steps = 0;
    for (int k = 0; k < 20; k++) if (v[k]) p = k;
    e = p - 4;
    if (e < 0) e = 0;
    if (e > 15) e = 15;
    while (e > 0 && v < base(e)) begin e--; steps++; end
    while (e < 15 && v >= base(e + 1)) begin e++; steps++; end
    return 4 + steps;
  endfunction

  task automatic enc(input int v, input int hold, output int code);
    int lat = 0;
    @(negedge clk);
    encInValid = 1'b1; encInValue = 20'(v);
    @(negedge clk);
    encInValid = 1'b0;
    while (!encOutValid && lat < 50) begin @(negedge clk); lat++; end
    code = encOutCode;
    chk(lat == refLat(v), "R6 latency", lat, refLat(v));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(encOutValid && encOutCode == 8'(code) && !encInReady, "R7 hold", encOutCode, code);
    end
    encOutReady = 1'b1;
    @(negedge clk);
    encOutReady = 1'b0;
    chk(!encOutValid && encInReady, "R7 release", encOutValid, 0);
  endtask

  task automatic dec(input int c, input int hold, output int val);
    @(negedge clk);
    decInValid = 1'b1; decInCode = 8'(c);
    @(negedge clk);
    decInValid = 1'b0;
    chk(decOutValid, "R8 one-cycle response", decOutValid, 1);
    val = decOutValue;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(decOutValid && decOutValue == 20'(val) && !decInReady, "R8 hold", decOutValue, val);
    end
    decOutReady = 1'b1;
    @(negedge clk);
    decOutReady = 1'b0;
    chk(!decOutValid && decInReady, "R8 release", decOutValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int code, val, prev;
    int vals[$] = '{16, 17, 31, 32, 47, 48, 100, 1000, 4079, 4080, 65520,
                    524271, 524272, 777777, 1015792};
    repeat (3) @(negedge clk);
    chk(encInReady && !encOutValid && decInReady && !decOutValid, "R7 R8 reset", encOutValid, 0);
    rstN = 1'b1;

    // R2: small values pass through
    foreach (vals[i]) begin end
    for (int v = 0; v < 16; v += 5) begin
      enc(v, 0, code);
      chk(code == v, "R2 small input", code, v);
    end
    enc(15, 0, code);
    chk(code == 15, "R2 small input", code, 15);

    // R3: segment selection and mantissa
    foreach (vals[i]) begin
      enc(vals[i], 0, code);
      chk(code == refEnc(vals[i]), "R3 encode", code, refEnc(vals[i]));
    end

    // R5: saturation
    enc(1015793, 0, code);
    chk(code == 255, "R5 saturate", code, 255);
    enc(1048575, 0, code);
    chk(code == 255, "R5 saturate", code, 255);

    // R7 / R8: hold under backpressure
    enc(300000, 5, code);
    chk(code == refEnc(300000), "R7 held code", code, refEnc(300000));
    dec(8'hA7, 4, val);
    chk(val == refDec(8'hA7), "R1 decode", val, refDec(8'hA7));

    // R1 / R4: every symbol round trips, strictly rising
    prev = -1;
    for (int c = 0; c < 256; c++) begin
      dec(c, 0, val);
      chk(val == refDec(c), "R1 decode", val, refDec(c));
      chk(val > prev, "R4 monotonic", val, prev + 1);
      prev = val;
      enc(val, 0, code);
      chk(code == c, "R4 round trip", code, c);
    end
    chk(prev == 1015792, "R5 top value", prev, 1015792);

    // R9: both paths at once
    fork
      begin int cc; enc(123456, 2, cc); chk(cc == refEnc(123456), "R9 concurrent encode", cc, refEnc(123456)); end
      begin int vv; dec(8'h5C, 3, vv); chk(vv == refDec(8'h5C), "R9 concurrent decode", vv, refDec(8'h5C)); end
    join

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule